// File: doc/BRIEF.md
# ADC Result Register Bank

This block keeps the most recent conversion result for every analog channel in a bank of per-channel registers. A converter presents a completion strobe with a channel index, a 10-bit sample and a 2-bit result-type code. The bank stores them in the register for that channel and marks it as holding fresh data. Channels 0 to 31 are internal, 32 to 63 are extended internal and 64 to 95 are external, which gives up to 96 registers. All of them behave the same way.

A host reads a channel by pulsing a read strobe with an address. The 32-bit word appears one cycle later. Reading a register consumes it, so the fresh-data and overwrite flags drop. A global overwrite-enable input chooses the policy for unread results. When it is high, new samples always replace old ones and the bank records that an unread sample was lost. When it is low, an unread sample is protected and later samples for that channel are dropped until the host reads it.

Top module: `adc_result_bank`

## Requirements
- R1: The read word uses big-endian numbering, so big-endian bit k is rd_data_o[31-k]. The fresh-data flag (big-endian bit 12) is rd_data_o[19]. The overwrite flag (bit 13) is rd_data_o[18]. The result-type code (bits 14–15) is rd_data_o[17:16]. The sample (bits 22–31) is rd_data_o[9:0]. The word for a read strobed in one cycle appears on rd_data_o after the next rising edge.
- R2: rd_data_o[31:20] and rd_data_o[15:10] always read as 0.
- R3: After reset, every register holds all zeros and rd_data_o is 0.
- R4: An accepted conversion stores the sample and the result-type code, and sets the fresh-data flag.
- R5: A read of an implemented channel returns the flags as they were before the read, then clears both the fresh-data flag and the overwrite flag.
- R6: While overwrite-enable is 0, a conversion for a channel whose fresh-data flag is 1 is discarded, and the stored word is unchanged.
- R7: While overwrite-enable is 0, the overwrite flag reads as 0.
- R8: While overwrite-enable is 1, every conversion is stored. The overwrite flag becomes 1 if the fresh-data flag was 1 at that edge, and 0 otherwise.
- R9: When a read and a conversion hit the same channel in the same cycle, the read returns the old contents. The new sample is then stored with the fresh-data flag at 1 and the overwrite flag at 0.
- R10: A read of an address of 96 or above returns 0 and changes nothing. A conversion with a channel index of 96 or above is ignored.
- R11: While the read strobe is low, rd_data_o holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| owr_en_i | input | 1 | Global overwrite-enable |
| cv_valid_i | input | 1 | Conversion-complete strobe |
| cv_chan_i | input | 7 | Channel index of the conversion |
| cv_data_i | input | 10 | Conversion sample |
| cv_tag_i | input | 2 | Result-type code |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | 7 | Channel to read |
| rd_data_o | output | 32 | Registered read word |

## Verification
A wrong flag or a wrong protection decision in one register shows up at the ports on the first read of that channel, one cycle after the strobe. A flag that fails to clear shows up on the second read. The sweeps write, overwrite and read every implemented channel under both policies. An error in the decoding of one channel index therefore appears as a mismatched sample on the first pass over the bank. A lost or spurious clear appears on the following pass. Same-cycle read and write collisions, and addresses beyond the bank, are checked one at a time.

// File: rtl/adcrb_pkg.sv
package adcrb_pkg;
  localparam int DATA_W  = 10;
  localparam int TAG_W   = 2;
  localparam int WORD_W  = 32;
  localparam int VLD_POS = 19;
  localparam int OVW_POS = 18;
  localparam int TAG_LSB = 16;

  typedef struct packed {
    logic              vld;
    logic              ovw;
    logic [TAG_W-1:0]  tag;
    logic [DATA_W-1:0] data;
  } slot_t;

  function automatic logic [WORD_W-1:0] pack_word(slot_t s, logic show_ovw);
    logic [WORD_W-1:0] w;
    w = '0;
    w[VLD_POS]                     = s.vld;
    w[OVW_POS]                     = s.ovw & show_ovw;
    w[TAG_LSB +: TAG_W]            = s.tag;
    w[DATA_W-1:0]                  = s.data;
    return w;
  endfunction
endpackage

// File: rtl/adcrb_rst_sync.sv
module adcrb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/adcrb_dec.sv
module adcrb_dec #(
  parameter int N  = 96,
  parameter int AW = 7
) (
  input  logic          en,
  input  logic [AW-1:0] addr,
  output logic [N-1:0]  hit
);
  for (genvar g = 0; g < N; g++) begin : g_hit
    assign hit[g] = en && (addr == AW'(g));
  end
endmodule

// File: rtl/adcrb_slot.sv
module adcrb_slot
  import adcrb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              owr_en,
  input  logic              wr_hit,
  input  logic              rd_hit,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [TAG_W-1:0]  wr_tag,
  output slot_t             q
);
  slot_t q_n;
  logic  accept;
  logic  flag_ovw;
  logic  upd;

  always_comb begin
    accept   = 1'b0;
    flag_ovw = 1'b0;
    if (wr_hit) begin
      if (rd_hit || !q.vld) begin
        accept   = 1'b1;
        flag_ovw = 1'b0;
      end else if (owr_en) begin
        accept   = 1'b1;
        flag_ovw = 1'b1;
      end
    end
  end

  always_comb begin
    q_n = q;
    if (rd_hit) begin
      q_n.vld = 1'b0;
      q_n.ovw = 1'b0;
    end
    if (accept) begin
      q_n.vld  = 1'b1;
      q_n.ovw  = flag_ovw;
      q_n.data = wr_data;
      q_n.tag  = wr_tag;
    end
  end

  assign upd = rd_hit | accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (upd) q <= q_n;
  end
endmodule

// File: rtl/adcrb_rdport.sv
module adcrb_rdport
  import adcrb_pkg::*;
#(
  parameter int NUM_CH = 96,
  parameter int AW     = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rd_en,
  input  logic [AW-1:0]            rd_addr,
  input  logic                     owr_en,
  input  slot_t [NUM_CH-1:0]       slots,
  output logic  [WORD_W-1:0]       rd_data
);
  localparam logic [AW:0] LIMIT = (AW+1)'(NUM_CH);

  logic              in_range;
  logic [WORD_W-1:0] word_n;
  slot_t             sel;

  assign in_range = ({1'b0, rd_addr} < LIMIT);

  always_comb begin
    sel = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (rd_addr == AW'(i)) sel = slots[i];
    end
  end

  always_comb begin
    word_n = '0;
    if (in_range) word_n = pack_word(sel, owr_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= word_n;
  end
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank
  import adcrb_pkg::*;
#(
  parameter int NUM_CH = 96,
  parameter int AW     = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              owr_en_i,
  input  logic              cv_valid_i,
  input  logic [AW-1:0]     cv_chan_i,
  input  logic [DATA_W-1:0] cv_data_i,
  input  logic [TAG_W-1:0]  cv_tag_i,
  input  logic              rd_en_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [WORD_W-1:0] rd_data_o
);
  logic               rst_sync_n;
  logic [NUM_CH-1:0]  wr_hit;
  logic [NUM_CH-1:0]  rd_hit;
  slot_t [NUM_CH-1:0] slot_q;

  adcrb_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  adcrb_dec #(.N(NUM_CH), .AW(AW)) u_wr_dec (
    .en   (cv_valid_i),
    .addr (cv_chan_i),
    .hit  (wr_hit)
  );

  adcrb_dec #(.N(NUM_CH), .AW(AW)) u_rd_dec (
    .en   (rd_en_i),
    .addr (rd_addr_i),
    .hit  (rd_hit)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_slot
    adcrb_slot u_slot (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .owr_en  (owr_en_i),
      .wr_hit  (wr_hit[c]),
      .rd_hit  (rd_hit[c]),
      .wr_data (cv_data_i),
      .wr_tag  (cv_tag_i),
      .q       (slot_q[c])
    );
  end

  adcrb_rdport #(.NUM_CH(NUM_CH), .AW(AW)) u_rdport (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .rd_en   (rd_en_i),
    .rd_addr (rd_addr_i),
    .owr_en  (owr_en_i),
    .slots   (slot_q),
    .rd_data (rd_data_o)
  );
endmodule

// File: rtl/adcrb_chk.sv
module adcrb_chk
  import adcrb_pkg::*;
#(
  parameter int NUM_CH = 96,
  parameter int AW     = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic               owr_en_i,
  input logic               cv_valid_i,
  input logic [AW-1:0]      cv_chan_i,
  input logic [DATA_W-1:0]  cv_data_i,
  input logic               rd_en_i,
  input logic [AW-1:0]      rd_addr_i,
  input logic [WORD_W-1:0]  rd_data_o,
  input slot_t [NUM_CH-1:0] slots
);
  localparam logic [AW:0] LIMIT = (AW+1)'(NUM_CH);

  logic wr_in, rd_in, same;
  assign wr_in = cv_valid_i && ({1'b0, cv_chan_i} < LIMIT);
  assign rd_in = rd_en_i && ({1'b0, rd_addr_i} < LIMIT);
  assign same  = wr_in && rd_in && (cv_chan_i == rd_addr_i);

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_o[31:20] == '0) && (rd_data_o[15:10] == '0));

  assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_in && !same) |=> (!slots[$past(rd_addr_i)].vld && !slots[$past(rd_addr_i)].ovw));

  assert_protect_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_in && !owr_en_i && slots[cv_chan_i].vld && !same)
      |=> (slots[$past(cv_chan_i)] == $past(slots[cv_chan_i])));

  assert_ovw_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && !owr_en_i) |=> !rd_data_o[OVW_POS]);

  assert_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_in && (owr_en_i || !slots[cv_chan_i].vld || same))
      |=> (slots[$past(cv_chan_i)].vld && slots[$past(cv_chan_i)].data == $past(cv_data_i)));

  assert_collide_R9: assert property (@(posedge clk) disable iff (!rst_n)
    same |=> !slots[$past(cv_chan_i)].ovw);

  assert_oor_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && !rd_in) |=> (rd_data_o == '0));

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> $stable(rd_data_o));
endmodule

bind adc_result_bank adcrb_chk #(.NUM_CH(NUM_CH), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .owr_en_i   (owr_en_i),
  .cv_valid_i (cv_valid_i),
  .cv_chan_i  (cv_chan_i),
  .cv_data_i  (cv_data_i),
  .rd_en_i    (rd_en_i),
  .rd_addr_i  (rd_addr_i),
  .rd_data_o  (rd_data_o),
  .slots      (slot_q)
);

// File: tb/adc_result_bank_tb.sv
module adc_result_bank_tb;
  localparam int NCH = 96;
  localparam int AW  = 7;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        owr_en_i, cv_valid_i, rd_en_i;
  logic [AW-1:0] cv_chan_i, rd_addr_i;
  logic [9:0]  cv_data_i;
  logic [1:0]  cv_tag_i;
  logic [31:0] rd_data_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  bit       m_v [NCH];
  bit       m_o [NCH];
  bit [1:0] m_t [NCH];
  bit [9:0] m_d [NCH];
  logic [31:0] last_word;

  always #5 clk = ~clk;

  adc_result_bank u_dut (
    .clk(clk), .rst_n(rst_n), .owr_en_i(owr_en_i), .cv_valid_i(cv_valid_i),
    .cv_chan_i(cv_chan_i), .cv_data_i(cv_data_i), .cv_tag_i(cv_tag_i),
    .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
  );

  function automatic logic [31:0] exp_word(int ch, bit owr);
    if (ch >= NCH) return 32'd0;
    return (32'(m_v[ch]) << 19) + (32'(m_o[ch] & owr) << 18) +
           (32'(m_t[ch]) << 16) + 32'(m_d[ch]);
  endfunction

  task automatic check(logic [31:0] act, logic [31:0] exp, string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic step(bit wr, int wch, int wd, int wt, bit rd, int ra, bit owr, string req);
    logic [31:0] e;
    owr_en_i   = owr;
    cv_valid_i = wr;
    cv_chan_i  = AW'(wch);
    cv_data_i  = 10'(wd);
    cv_tag_i   = 2'(wt);
    rd_en_i    = rd;
    rd_addr_i  = AW'(ra);
    e = exp_word(ra, owr);
    @(posedge clk); #1;
    if (rd) begin
      check(rd_data_o, e, req);
      last_word = e;
    end
    if (rd && ra < NCH) begin m_v[ra] = 0; m_o[ra] = 0; end
    if (wr && wch < NCH) begin
      if (!m_v[wch]) begin
        m_v[wch] = 1; m_o[wch] = 0; m_d[wch] = 10'(wd); m_t[wch] = 2'(wt);
      end else if (owr) begin
        m_v[wch] = 1; m_o[wch] = 1; m_d[wch] = 10'(wd); m_t[wch] = 2'(wt);
      end
    end
    cv_valid_i = 0;
    rd_en_i    = 0;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 50000) begin
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    for (int i = 0; i < NCH; i++) begin m_v[i] = 0; m_o[i] = 0; m_t[i] = 0; m_d[i] = 0; end
    rst_n = 0; owr_en_i = 0; cv_valid_i = 0; rd_en_i = 0;
    cv_chan_i = 0; rd_addr_i = 0; cv_data_i = 0; cv_tag_i = 0;
    #1;
    check(rd_data_o, 32'd0, "R3 reset output");
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    #1;
    // R3 R10: every address after reset, including those beyond the bank
    for (int a = 0; a < 128; a++) step(0, 0, 0, 0, 1, a, 1, "R3/R10 reset sweep");
    // R4 R1: protected mode, first write per channel
    for (int c = 0; c < NCH; c++) step(1, c, (c*37+5) % 1024, c % 4, 0, 0, 0, "R4");
    // R6: second write discarded
    for (int c = 0; c < NCH; c++) step(1, c, (c*11+900) % 1024, (c+1) % 4, 0, 0, 0, "R6");
    // R10: out-of-range writes ignored
    for (int c = NCH; c < 128; c++) step(1, c, 1023, 3, 0, 0, 0, "R10 write");
    for (int c = 0; c < NCH; c++) step(0, 0, 0, 0, 1, c, 0, "R1/R4/R6 read");
    for (int c = 0; c < NCH; c++) step(0, 0, 0, 0, 1, c, 0, "R5 second read");
    // R8: overwrite mode, double writes on even channels
    for (int c = 0; c < NCH; c++) step(1, c, (c*5+1) % 1024, 3 - c % 4, 0, 0, 1, "R8 first");
    for (int c = 0; c < NCH; c += 2) step(1, c, (c*13+77) % 1024, c % 4, 0, 0, 1, "R8 second");
    // R7: flag masked while protected
    step(0, 0, 0, 0, 1, 0, 0, "R7 masked");
    for (int c = 1; c < NCH; c++) step(0, 0, 0, 0, 1, c, 1, "R8/R1 read");
    for (int c = 0; c < NCH; c += 7) step(0, 0, 0, 0, 1, c, 1, "R5 cleared");
    // R9: collisions on a set channel, with both policies
    for (int c = 0; c < NCH; c += 5) step(1, c, c + 100, 1, 0, 0, c % 2, "R9 setup");
    for (int c = 0; c < NCH; c += 5) step(1, c, c + 300, 2, 1, c, c % 2, "R9 collide");
    for (int c = 0; c < NCH; c += 5) step(0, 0, 0, 0, 1, c, 1, "R9 after");
    // R10: reads beyond the bank leave a valid channel untouched
    step(1, 3, 555, 1, 0, 0, 0, "R10 setup");
    step(0, 0, 0, 0, 1, 100, 0, "R10 oor read");
    step(0, 0, 0, 0, 1, 127, 0, "R10 oor read");
    step(0, 0, 0, 0, 1, 3, 0, "R10 intact");
    // R11: output holds with no read strobe
    step(1, 3, 12, 2, 0, 0, 1, "R11 idle");
    check(rd_data_o, last_word, "R11 hold");
    step(0, 0, 0, 0, 0, 0, 1, "R11 idle");
    check(rd_data_o, last_word, "R11 hold");
    // R2 spot check on an all-ones sample
    step(1, 9, 1023, 3, 0, 0, 1, "R2 setup");
    step(0, 0, 0, 0, 1, 9, 1, "R2 read");
    n_chk++;
    if ((rd_data_o[31:20] != 0) || (rd_data_o[15:10] != 0)) begin
      n_fail++;
      $display("FAIL R2: actual %08h expected reserved bits 0", rd_data_o);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule